// File: doc/BRIEF.md
# Single-Channel Circular DMA Engine

This block is one DMA channel. Software programs a peripheral-side base address, a memory-side base address, an item count and a control word through a small register port. Once the channel is enabled it moves one data item per peripheral request, or back to back with no request in memory-to-memory mode. Each item is a read beat on the source side followed by a write beat on the destination side, both on a single-beat bus master port.

The channel keeps its own working copies of both addresses and of the remaining item count. Software cannot see the working addresses. The channel advances them and decrements the count after every item. When the count runs out, the channel either stops (one-shot mode) or, in circular mode, reloads the count and both working addresses from the programmed values and carries on. Half-way and completion events set sticky flags. Each flag can drive the single interrupt output through its own enable.

Top module: `dma_ring_channel`

## Requirements
- R1: After reset the bus request, the acknowledge and the interrupt are low, and every readable register (offsets 0 to 4) reads zero.
- R2: Register offsets are: 0 control, 1 peripheral base, 2 memory base, 3 count (a write sets the programmed count, a read returns the remaining count), 4 flags (bit 0 complete, bit 1 half), 5 flag clear. A write to offset 3 is ignored while control bit 0 (enable) is set. Clearing enable leaves the base, count and control values unchanged.
- R3: Control bits are: 0 enable, 1 complete-interrupt enable, 2 half-interrupt enable, 3 direction (0: peripheral side to memory side, 1: the reverse), 4 circular, 5 peripheral increment, 6 memory increment, 8:7 peripheral size, 10:9 memory size, 12:11 priority (stored only), 13 memory-to-memory. Each item is a read at the source working address with the source size, then a write of the read data to the destination working address with the destination size. A beat holds its request, address and direction until bus_ready.
- R4: Size codes are 00 = 1 byte, 01 = 2 bytes and 10 = 4 bytes. After each item a working address grows by its side's size only when that side's increment bit is set, and stays fixed otherwise.
- R5: The remaining count falls by one after each completed item.
- R6: In one-shot mode, once the remaining count is zero, requests start no further bus activity.
- R7: In circular mode, after the item that empties the count, the remaining count reloads from the programmed count, both working addresses reload from the base registers, and servicing continues.
- R8: The half flag sets after the item that leaves the remaining count equal to the programmed count shifted right by one.
- R9: The complete flag sets after the item that empties the count. Both flags are sticky. Writing 1 to bit 0 (complete) or bit 1 (half) of offset 5 clears that flag.
- R10: irq is high exactly when some flag is set whose interrupt enable bit is also set.
- R11: dack pulses high for one cycle after the write beat of each request-driven item. It never pulses in memory-to-memory mode.
- R12: In memory-to-memory mode the channel runs items back to back with dreq low, until the count is used up.
- R13: While disabled, requests start no item. Setting enable loads both working addresses from the base registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | One-cycle acknowledge per served request |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | DATA_W | Write data |
| bus_size | output | 2 | Beat size code |
| bus_rdata | input | DATA_W | Read data, valid with bus_ready |
| bus_ready | input | 1 | Beat completes this cycle |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with ADDR_W = 16, DATA_W = 32 and CNT_W = 8. With the narrow address, the read data can be derived from the beat address, so every written value traces back to its source address. With the short count, one-shot, circular and memory-to-memory blocks of three or four items fit, and several circular wraps fit in one short run. The odd count of three makes the half threshold round down, and the bench checks where that lands.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_ACK
   } seq_state_e;

   // control word, most significant field first
   typedef struct packed {
      logic       m2m;
      logic [1:0] prio;
      logic [1:0] msize;
      logic [1:0] psize;
      logic       minc;
      logic       pinc;
      logic       circ;
      logic       dir;
      logic       ht_ie;
      logic       tc_ie;
      logic       en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'b00:   size_bytes = 3'd1;
         2'b01:   size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dma_ring_ptr.sv
module dma_ring_ptr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              advance,
   input  logic              inc_en,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] cur
);
   import dma_ring_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur <= '0;
      else if (load)
         cur <= base;
      else if (advance && inc_en)
         cur <= cur + ADDR_W'(size_bytes(size));
   end

endmodule

// File: rtl/dma_ring_regs.sv
module dma_ring_regs #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [2:0]               reg_addr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   input  logic [CNT_W-1:0]         rem,
   input  logic                     set_tc,
   input  logic                     set_ht,
   output dma_ring_pkg::ctrl_t      ctrl,
   output logic [ADDR_W-1:0]        pbase,
   output logic [ADDR_W-1:0]        mbase,
   output logic [CNT_W-1:0]         cnt_base,
   output logic                     cnt_load,
   output logic                     start,
   output logic                     irq
);
   import dma_ring_pkg::*;

   localparam logic [2:0] OFS_CTRL  = 3'd0;
   localparam logic [2:0] OFS_PBASE = 3'd1;
   localparam logic [2:0] OFS_MBASE = 3'd2;
   localparam logic [2:0] OFS_COUNT = 3'd3;
   localparam logic [2:0] OFS_FLAGS = 3'd4;
   localparam logic [2:0] OFS_CLEAR = 3'd5;

   logic flag_tc, flag_ht;
   logic wr_ctrl, wr_clear;
   logic unused_wdata;

   assign unused_wdata = ^reg_wdata;
   assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
   assign wr_clear = reg_wr && (reg_addr == OFS_CLEAR);
   assign cnt_load = reg_wr && (reg_addr == OFS_COUNT) && !ctrl.en;
   assign start    = wr_ctrl && reg_wdata[0] && !ctrl.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         pbase    <= '0;
         mbase    <= '0;
         cnt_base <= '0;
      end else begin
         if (wr_ctrl)
            ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (reg_wr && reg_addr == OFS_PBASE)
            pbase <= reg_wdata[ADDR_W-1:0];
         if (reg_wr && reg_addr == OFS_MBASE)
            mbase <= reg_wdata[ADDR_W-1:0];
         if (cnt_load)
            cnt_base <= reg_wdata[CNT_W-1:0];
      end
   end

   // sticky flags; a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_tc <= 1'b0;
         flag_ht <= 1'b0;
      end else begin
         if (set_tc)
            flag_tc <= 1'b1;
         else if (wr_clear && reg_wdata[0])
            flag_tc <= 1'b0;
         if (set_ht)
            flag_ht <= 1'b1;
         else if (wr_clear && reg_wdata[1])
            flag_ht <= 1'b0;
      end
   end

   assign irq = (flag_tc && ctrl.tc_ie) || (flag_ht && ctrl.ht_ie);

   always_comb begin
      case (reg_addr)
         OFS_CTRL:  reg_rdata = {{(32-CTRL_W){1'b0}}, ctrl};
         OFS_PBASE: reg_rdata = 32'(pbase);
         OFS_MBASE: reg_rdata = 32'(mbase);
         OFS_COUNT: reg_rdata = 32'(rem);
         OFS_FLAGS: reg_rdata = {30'd0, flag_ht, flag_tc};
         default:   reg_rdata = 32'd0;
      endcase
   end

endmodule

// File: rtl/dma_ring_seq.sv
module dma_ring_seq #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              m2m,
   input  logic              circ,
   input  logic              dir,
   input  logic [1:0]        psize,
   input  logic [1:0]        msize,
   input  logic [CNT_W-1:0]  cnt_base,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_wval,
   input  logic [ADDR_W-1:0] p_cur,
   input  logic [ADDR_W-1:0] m_cur,
   input  logic              dreq,
   output logic              dack,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ready,
   output logic [CNT_W-1:0]  rem,
   output logic              advance,
   output logic              wrap,
   output logic              set_tc,
   output logic              set_ht
);
   import dma_ring_pkg::*;

   seq_state_e        state;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [1:0]        ssz_q, dsz_q;
   logic              item_m2m;
   logic              go, done;
   logic [CNT_W-1:0]  rem_next;

   assign go       = (state == ST_IDLE) && en && (rem != '0) && (dreq || m2m);
   assign done     = (state == ST_WRITE) && bus_ready;
   assign rem_next = rem - 1'b1;
   assign advance  = done;
   assign wrap     = done && (rem_next == '0) && circ;
   assign set_tc   = done && (rem_next == '0);
   assign set_ht   = done && (rem_next == (cnt_base >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         data_q   <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         ssz_q    <= '0;
         dsz_q    <= '0;
         item_m2m <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (go) begin
               state    <= ST_READ;
               item_m2m <= m2m;
               src_q    <= dir ? m_cur : p_cur;
               dst_q    <= dir ? p_cur : m_cur;
               ssz_q    <= dir ? msize : psize;
               dsz_q    <= dir ? psize : msize;
            end
            ST_READ: if (bus_ready) begin
               data_q <= bus_rdata;
               state  <= ST_WRITE;
            end
            ST_WRITE: if (bus_ready) state <= ST_ACK;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem <= '0;
      else if (cnt_load)
         rem <= cnt_wval;
      else if (wrap)
         rem <= cnt_base;
      else if (done)
         rem <= rem_next;
   end

   assign bus_req   = (state == ST_READ) || (state == ST_WRITE);
   assign bus_we    = (state == ST_WRITE);
   assign bus_addr  = (state == ST_WRITE) ? dst_q : src_q;
   assign bus_size  = (state == ST_WRITE) ? dsz_q : ssz_q;
   assign bus_wdata = (state == ST_WRITE) ? data_q : '0;
   assign dack      = (state == ST_ACK) && !item_m2m;

endmodule

// File: rtl/dma_ring_channel.sv
module dma_ring_channel #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              dreq,
   output logic              dack,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ready,
   output logic              irq
);
   import dma_ring_pkg::*;

   localparam int NUM_PTR = 2;

   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr_w
      $error("dma_ring_channel: ADDR_W must lie in 4..32");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("dma_ring_channel: CNT_W must lie in 2..32");
   end
   if (DATA_W < 8) begin : g_bad_data_w
      $error("dma_ring_channel: DATA_W must be at least 8");
   end

   ctrl_t             ctrl_q;
   logic [ADDR_W-1:0] pbase, mbase;
   logic [CNT_W-1:0]  cnt_base, rem;
   logic              cnt_load, start;
   logic              advance, wrap, set_tc, set_ht;
   logic              ctrl_en, ctrl_circ;

   logic [ADDR_W-1:0] base_a [NUM_PTR];
   logic [ADDR_W-1:0] cur_a  [NUM_PTR];
   logic              inc_a  [NUM_PTR];
   logic [1:0]        size_a [NUM_PTR];

   assign ctrl_en   = ctrl_q.en;
   assign ctrl_circ = ctrl_q.circ;

   dma_ring_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .rem      (rem),
      .set_tc   (set_tc),
      .set_ht   (set_ht),
      .ctrl     (ctrl_q),
      .pbase    (pbase),
      .mbase    (mbase),
      .cnt_base (cnt_base),
      .cnt_load (cnt_load),
      .start    (start),
      .irq      (irq)
   );

   // index 0: peripheral side, index 1: memory side
   assign base_a[0] = pbase;
   assign base_a[1] = mbase;
   assign inc_a[0]  = ctrl_q.pinc;
   assign inc_a[1]  = ctrl_q.minc;
   assign size_a[0] = ctrl_q.psize;
   assign size_a[1] = ctrl_q.msize;

   for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
      dma_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (start || wrap),
         .base   (base_a[gi]),
         .advance(advance),
         .inc_en (inc_a[gi]),
         .size   (size_a[gi]),
         .cur    (cur_a[gi])
      );
   end

   dma_ring_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_q.en),
      .m2m      (ctrl_q.m2m),
      .circ     (ctrl_q.circ),
      .dir      (ctrl_q.dir),
      .psize    (ctrl_q.psize),
      .msize    (ctrl_q.msize),
      .cnt_base (cnt_base),
      .cnt_load (cnt_load),
      .cnt_wval (reg_wdata[CNT_W-1:0]),
      .p_cur    (cur_a[0]),
      .m_cur    (cur_a[1]),
      .dreq     (dreq),
      .dack     (dack),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_size (bus_size),
      .bus_rdata(bus_rdata),
      .bus_ready(bus_ready),
      .rem      (rem),
      .advance  (advance),
      .wrap     (wrap),
      .set_tc   (set_tc),
      .set_ht   (set_ht)
   );

endmodule

// File: rtl/dma_ring_channel_chk.sv
module dma_ring_channel_chk #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dack,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_ready,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              en,
   input logic              circ,
   input logic [CNT_W-1:0]  rem
);

   // R11
   dack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dack |=> !dack);

   // R3
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R13
   start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(en));

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rem == '0) && !circ && !bus_req) |=> !bus_req);

endmodule

bind dma_ring_channel dma_ring_channel_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dack     (dack),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_ready(bus_ready),
   .bus_addr (bus_addr),
   .en       (ctrl_en),
   .circ     (ctrl_circ),
   .rem      (rem)
);

// File: tb/dma_ring_channel_bench.sv
module dma_ring_channel_bench;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 8;

   typedef struct {
      logic              we;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
      logic [1:0]        size;
   } beat_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              dreq = 1'b0;
   logic              dack;
   logic              bus_req, bus_we;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata, bus_rdata;
   logic [1:0]        bus_size;
   logic              bus_ready;
   logic              irq;

   int    checks = 0;
   int    fails = 0;
   int    dack_cnt = 0;
   beat_t expq[$];

   always #5 clk = ~clk;

   dma_ring_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dma_ring_channel (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .irq(irq)
   );

   function automatic logic [DATA_W-1:0] rdval(input logic [ADDR_W-1:0] a);
      return {a, ~a};
   endfunction

   // bus slave: one wait cycle per beat, read data derived from the address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_ready <= 1'b0;
      else        bus_ready <= bus_req && !bus_ready;
   end
   assign bus_rdata = rdval(bus_addr);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && bus_req && bus_ready) begin
         checks++;
         if (expq.size() == 0) begin
            fails++;
            $display("FAIL R3 unexpected beat: actual addr %h expected none", bus_addr);
         end else begin
            beat_t e;
            e = expq.pop_front();
            if (bus_we !== e.we || bus_addr !== e.addr || bus_size !== e.size ||
                (e.we && bus_wdata !== e.data)) begin
               fails++;
               $display("FAIL R3/R4 beat: actual we%0b %h sz%0d %h expected we%0b %h sz%0d %h",
                        bus_we, bus_addr, bus_size, bus_wdata, e.we, e.addr, e.size, e.data);
            end
         end
      end
      if (dack) dack_cnt++;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] cw(input logic en, tcie, htie, dir, circ, pinc, minc,
                                      input logic [1:0] psz, msz, input logic m2m);
      return {18'd0, m2m, 2'b01, msz, psz, minc, pinc, circ, dir, htie, tcie, en};
   endfunction

   task automatic push_item(input logic [ADDR_W-1:0] src, dst, input logic [1:0] ssz, dsz);
      beat_t r, w;
      r.we = 1'b0; r.addr = src; r.data = '0;        r.size = ssz;
      w.we = 1'b1; w.addr = dst; w.data = rdval(src); w.size = dsz;
      expq.push_back(r);
      expq.push_back(w);
   endtask

   task automatic serve;
      @(negedge clk);
      dreq = 1'b1;
      for (int n = 0; n < 200 && !dack; n++) @(negedge clk);
      if (!dack) chk("R11 acknowledge seen", 32'd0, 32'd1);
      dreq = 1'b0;
   endtask

   task automatic drain;
      for (int n = 0; n < 300 && (expq.size() != 0 || bus_req); n++) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] cfg;
      int busy;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R1 bus_req", 32'(bus_req), 32'd0);
      chk("R1 dack", 32'(dack), 32'd0);
      chk("R1 irq", 32'(irq), 32'd0);
      for (int a = 0; a < 5; a++) begin
         rd_reg(3'(a), v);
         chk("R1 register", v, 32'd0);
      end

      // one-shot: peripheral -> memory, fixed peripheral address, memory +2
      cfg = cw(0, 1, 1, 0, 0, 0, 1, 2'b10, 2'b01, 0);
      wr_reg(3'd0, cfg);
      wr_reg(3'd1, 32'h4000);
      wr_reg(3'd2, 32'h0100);
      wr_reg(3'd3, 32'd4);
      dreq = 1'b1;
      busy = 0;
      for (int n = 0; n < 10; n++) begin @(negedge clk); if (bus_req) busy++; end
      dreq = 1'b0;
      chk("R13 no activity while disabled", 32'(busy), 32'd0);
      wr_reg(3'd0, cfg | 32'd1);
      rd_reg(3'd1, v);
      chk("R2 peripheral base readback", v, 32'h4000);
      for (int i = 0; i < 4; i++) begin
         push_item(16'h4000, 16'(16'h0100 + 2 * i), 2'b10, 2'b01);
         serve();
         rd_reg(3'd3, v);
         chk("R5 remaining count", v, 32'(3 - i));
         if (i == 0) begin
            rd_reg(3'd4, v);
            chk("R8 half flag not yet", v, 32'd0);
         end
         if (i == 1) begin
            rd_reg(3'd4, v);
            chk("R8 half flag", v, 32'd2);
            chk("R10 irq from half", 32'(irq), 32'd1);
         end
      end
      rd_reg(3'd4, v);
      chk("R9 complete flag", v, 32'd3);
      chk("R11 acknowledge count", 32'(dack_cnt), 32'd4);
      chk("R3 queue drained", 32'(expq.size()), 32'd0);

      dreq = 1'b1;
      busy = 0;
      for (int n = 0; n < 20; n++) begin @(negedge clk); if (bus_req) busy++; end
      dreq = 1'b0;
      chk("R6 idle at zero", 32'(busy), 32'd0);

      wr_reg(3'd3, 32'd9);
      rd_reg(3'd3, v);
      chk("R2 count write ignored while enabled", v, 32'd0);

      wr_reg(3'd5, 32'd1);
      rd_reg(3'd4, v);
      chk("R9 clear complete only", v, 32'd2);
      chk("R10 irq with half left", 32'(irq), 32'd1);
      wr_reg(3'd5, 32'd2);
      rd_reg(3'd4, v);
      chk("R9 clear half", v, 32'd0);
      chk("R10 irq after clear", 32'(irq), 32'd0);

      wr_reg(3'd0, cfg);
      rd_reg(3'd1, v);
      chk("R2 peripheral base kept", v, 32'h4000);
      rd_reg(3'd2, v);
      chk("R2 memory base kept", v, 32'h0100);
      rd_reg(3'd0, v);
      chk("R2 control kept", v, cfg);

      // circular: memory -> peripheral, both increment, interrupts masked
      cfg = cw(0, 0, 0, 1, 1, 1, 1, 2'b10, 2'b00, 0);
      wr_reg(3'd0, cfg);
      wr_reg(3'd1, 32'h2000);
      wr_reg(3'd2, 32'h0300);
      wr_reg(3'd3, 32'd3);
      wr_reg(3'd0, cfg | 32'd1);
      for (int i = 0; i < 7; i++) begin
         push_item(16'(16'h0300 + (i % 3)), 16'(16'h2000 + 4 * (i % 3)), 2'b00, 2'b10);
         serve();
         if (i == 1) begin
            rd_reg(3'd4, v);
            chk("R8 half flag rounds down", v, 32'd2);
         end
         if (i == 2) begin
            rd_reg(3'd3, v);
            chk("R7 count reloaded", v, 32'd3);
         end
      end
      rd_reg(3'd3, v);
      chk("R7 count after wraps", v, 32'd2);
      rd_reg(3'd4, v);
      chk("R9 flags in circular", v, 32'd3);
      chk("R10 irq masked", 32'(irq), 32'd0);
      chk("R7 queue drained", 32'(expq.size()), 32'd0);

      // memory to memory: no request
      wr_reg(3'd0, cfg);
      wr_reg(3'd5, 32'd3);
      cfg = cw(0, 1, 0, 0, 0, 1, 1, 2'b10, 2'b10, 1);
      wr_reg(3'd0, cfg);
      wr_reg(3'd1, 32'h5000);
      wr_reg(3'd2, 32'h0600);
      wr_reg(3'd3, 32'd3);
      for (int i = 0; i < 3; i++)
         push_item(16'(16'h5000 + 4 * i), 16'(16'h0600 + 4 * i), 2'b10, 2'b10);
      busy = dack_cnt;
      wr_reg(3'd0, cfg | 32'd1);
      drain();
      chk("R12 items done without request", 32'(expq.size()), 32'd0);
      rd_reg(3'd3, v);
      chk("R12 count used up", v, 32'd0);
      rd_reg(3'd4, v);
      chk("R12 flags after block", v, 32'd3);
      chk("R10 irq from complete", 32'(irq), 32'd1);
      chk("R11 no acknowledge in m2m", 32'(dack_cnt), 32'(busy));

      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule